// File: doc/BRIEF.md
# Partial Register Stall Detector

This block watches an in-order stream of decoded instructions, one per cycle. It raises a hold when an instruction reads a general-purpose register in a way that depends on an earlier write to only part of that register, while that write has not yet retired. Each of the eight 32-bit registers is split into three lanes: byte 0, byte 1, and the upper half. The block keeps, per register, the lanes that have pending partial writes, the tag of the youngest such write, and a known-zero flag.

An instruction is presented with a valid bit, an optional destination (register and part), up to two sources (register and part each), and a flag. The flag marks a zero idiom, meaning an XOR or SUB of a register with itself. Every valid slot is numbered by a slot counter, and the number of the presented slot is shown on `issue_tag`. The number of an accepted instruction is its tag. A retire pulse returns that tag when the write retires. While the hold is raised, the presented instruction is not accepted and must be presented again. In static mode, a partial write is also treated as retired once a fixed number of later valid slots have been presented.

Top module: `prsd_top`

## Requirements
- R1: Synchronous active-low reset clears all pending lanes, tags, known-zero flags and the slot counter. After reset, no read stalls and `issue_tag` reads 0.
- R2: Part codes are 0 = byte 0, 1 = byte 1, 2 = 16-bit (byte 0 and byte 1), 3 = full 32-bit. A read of the 16-bit or full part of a register stalls while an unretired write to a smaller part of it is pending, including when other instructions lie between the two.
- R3: Writing byte 1 and then reading byte 0 of the same register stalls, and so does the reverse order.
- R4: A read whose lanes all lie inside the lanes already pending for that register does not stall. Examples are the same part that was written, or a byte of a pending 16-bit write.
- R5: A retire pulse whose tag equals a register's pending tag clears that register's pending lanes. A stall held on it drops in the cycle after the pulse. A pulse with any other tag changes nothing.
- R6: An accepted full 32-bit write clears the pending lanes of its destination, so a following read of that register does not stall.
- R7: An accepted full write flagged as a zero idiom sets the destination's known-zero flag. While the flag is set, partial writes followed by any read do not stall. A zero idiom's own sources never stall it.
- R8: A full write without the zero-idiom flag, such as moving the value zero, clears the known-zero flag, so a later partial write followed by a full read stalls.
- R9: A 16-bit write clears the known-zero flag, so a full read after it stalls.
- R10: In static mode (`static_mode` = 1), a pending partial write made in slot t stops causing stalls from slot t + 1 + DIST onward. Held slots count as slots.
- R11: While `stall` is high, `accept` is low and `stall_reg` names the offending source register, with source 0 taking priority over source 1. Without `in_valid` there is no stall.
- R12: The slot counter shown on `issue_tag` advances by one on every cycle with `in_valid` high, whether the slot is accepted or held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| static_mode | input | 1 | Retire partial writes by slot distance |
| in_valid | input | 1 | An instruction is presented |
| dst_en | input | 1 | Instruction writes a register |
| dst_reg | input | 3 | Destination register index |
| dst_part | input | 2 | Destination part code |
| zero_idiom | input | 1 | Instruction is a self-XOR or self-SUB |
| src0_en | input | 1 | Source 0 is read |
| src0_reg | input | 3 | Source 0 register index |
| src0_part | input | 2 | Source 0 part code |
| src1_en | input | 1 | Source 1 is read |
| src1_reg | input | 3 | Source 1 register index |
| src1_part | input | 2 | Source 1 part code |
| retire_valid | input | 1 | A tagged write retires |
| retire_tag | input | 6 | Tag of the retiring write |
| stall | output | 1 | Presented instruction is held |
| stall_reg | output | 3 | Register causing the hold |
| accept | output | 1 | Presented instruction is taken |
| issue_tag | output | 6 | Slot number of the presented instruction |

## Verification
`stall`, `stall_reg` and `accept` follow the presented instruction in the same cycle, using state registered at the previous edge. The bench therefore drives each slot just after a falling edge and samples one nanosecond later, before the rising edge that commits the slot. The effect of an accepted write or of a retire pulse is due one rising edge later. For this reason, retire checks look at the held instruction both in the pulse cycle (still stalled) and in the next cycle (released). Static-mode checks count held slots one by one until the release.

// File: rtl/prsd_pkg.sv
package prsd_pkg;

    localparam int LANES = 3;

    typedef enum logic [1:0] {
        PART_LO   = 2'd0,
        PART_HI   = 2'd1,
        PART_WORD = 2'd2,
        PART_FULL = 2'd3
    } part_e;

    function automatic logic [LANES-1:0] part_lanes(part_e p);
        case (p)
            PART_LO:   return 3'b001;
            PART_HI:   return 3'b010;
            PART_WORD: return 3'b011;
            default:   return 3'b111;
        endcase
    endfunction

endpackage

// File: rtl/prsd_src_check.sv
module prsd_src_check
    import prsd_pkg::*;
#(
    parameter int NREG = 8
) (
    input  logic                            en,
    input  logic [$clog2(NREG)-1:0]         idx,
    input  logic [1:0]                      part,
    input  logic [NREG-1:0][LANES-1:0]      live,
    input  logic [NREG-1:0]                 kz,
    output logic                            hit
);

    logic [LANES-1:0] held;
    logic [LANES-1:0] want;

    always_comb begin
        held = live[idx];
        want = part_lanes(part_e'(part));
        // outside the pending lanes, or a sibling byte: must wait
        hit  = en && (held != '0) && !kz[idx] && ((want & ~held) != '0);
    end

endmodule

// File: rtl/prsd_age.sv
module prsd_age #(
    parameter int NREG  = 8,
    parameter int TAG_W = 6,
    parameter int DIST  = 4
) (
    input  logic                        static_mode,
    input  logic [TAG_W-1:0]            slot,
    input  logic [NREG-1:0][TAG_W-1:0]  tags,
    input  logic                        retire_valid,
    input  logic [TAG_W-1:0]            retire_tag,
    output logic [NREG-1:0]             expired,
    output logic [NREG-1:0]             retired
);

    localparam logic [TAG_W-1:0] ONE    = TAG_W'(1);
    localparam logic [TAG_W-1:0] DIST_T = TAG_W'(DIST);

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        logic [TAG_W-1:0] age;
        // slots presented after the tagged write
        assign age        = slot - tags[g] - ONE;
        assign expired[g] = static_mode && (age >= DIST_T);
        assign retired[g] = retire_valid && (retire_tag == tags[g]);
    end

endmodule

// File: rtl/prsd_top.sv
module prsd_top
    import prsd_pkg::*;
#(
    parameter int NREG  = 8,
    parameter int TAG_W = 6,
    parameter int DIST  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    static_mode,
    input  logic                    in_valid,
    input  logic                    dst_en,
    input  logic [$clog2(NREG)-1:0] dst_reg,
    input  logic [1:0]              dst_part,
    input  logic                    zero_idiom,
    input  logic                    src0_en,
    input  logic [$clog2(NREG)-1:0] src0_reg,
    input  logic [1:0]              src0_part,
    input  logic                    src1_en,
    input  logic [$clog2(NREG)-1:0] src1_reg,
    input  logic [1:0]              src1_part,
    input  logic                    retire_valid,
    input  logic [TAG_W-1:0]        retire_tag,
    output logic                    stall,
    output logic [$clog2(NREG)-1:0] stall_reg,
    output logic                    accept,
    output logic [TAG_W-1:0]        issue_tag
);

    localparam int RW   = $clog2(NREG);
    localparam int NSRC = 2;

    typedef struct packed {
        logic [NREG-1:0][LANES-1:0] mask;
        logic [NREG-1:0][TAG_W-1:0] tag;
        logic [NREG-1:0]            kz;
        logic [TAG_W-1:0]           slot;
    } state_t;

    state_t st_d, st_q;

    logic [NREG-1:0]            expired, retired;
    logic [NREG-1:0][LANES-1:0] live;
    logic [NSRC-1:0]            s_en, hit;
    logic [NSRC-1:0][RW-1:0]    s_idx;
    logic [NSRC-1:0][1:0]       s_part;
    logic                       idiom, hazard;

    prsd_age #(.NREG(NREG), .TAG_W(TAG_W), .DIST(DIST)) u_age (
        .static_mode  (static_mode),
        .slot         (st_q.slot),
        .tags         (st_q.tag),
        .retire_valid (retire_valid),
        .retire_tag   (retire_tag),
        .expired      (expired),
        .retired      (retired)
    );

    always_comb begin
        for (int r = 0; r < NREG; r++) begin
            live[r] = expired[r] ? '0 : st_q.mask[r];
        end
    end

    assign s_en   = {src1_en, src0_en};
    assign s_idx  = {src1_reg, src0_reg};
    assign s_part = {src1_part, src0_part};

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        prsd_src_check #(.NREG(NREG)) u_chk (
            .en   (s_en[i]),
            .idx  (s_idx[i]),
            .part (s_part[i]),
            .live (live),
            .kz   (st_q.kz),
            .hit  (hit[i])
        );
    end

    assign idiom     = zero_idiom && dst_en && (part_e'(dst_part) == PART_FULL);
    assign hazard    = (|hit) && !idiom;
    assign stall     = in_valid && hazard;
    assign accept    = in_valid && !hazard;
    assign issue_tag = st_q.slot;

    always_comb begin
        stall_reg = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (hit[i]) stall_reg = s_idx[i];
        end
        if (!stall) stall_reg = '0;
    end

    always_comb begin
        st_d = st_q;
        for (int r = 0; r < NREG; r++) begin
            if (expired[r] || retired[r]) st_d.mask[r] = '0;
        end
        if (in_valid) st_d.slot = st_q.slot + TAG_W'(1);
        if (accept && dst_en) begin
            case (part_e'(dst_part))
                PART_FULL: begin
                    st_d.mask[dst_reg] = '0;
                    st_d.kz[dst_reg]   = idiom;
                end
                PART_WORD: begin
                    st_d.mask[dst_reg] = st_d.mask[dst_reg] | part_lanes(PART_WORD);
                    st_d.tag[dst_reg]  = st_q.slot;
                    st_d.kz[dst_reg]   = 1'b0;
                end
                default: begin
                    st_d.mask[dst_reg] = st_d.mask[dst_reg] | part_lanes(part_e'(dst_part));
                    st_d.tag[dst_reg]  = st_q.slot;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/prsd_checker.sv
module prsd_checker #(
    parameter int NREG  = 8,
    parameter int TAG_W = 6
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    in_valid,
    input logic                    dst_en,
    input logic [$clog2(NREG)-1:0] dst_reg,
    input logic [1:0]              dst_part,
    input logic                    src0_en,
    input logic [$clog2(NREG)-1:0] src0_reg,
    input logic                    src1_en,
    input logic [$clog2(NREG)-1:0] src1_reg,
    input logic                    stall,
    input logic [$clog2(NREG)-1:0] stall_reg,
    input logic                    accept,
    input logic [TAG_W-1:0]        issue_tag
);

    p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!stall && issue_tag == '0));

    p_stall_names_source_r11: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> ((src0_en && src0_reg == stall_reg) || (src1_en && src1_reg == stall_reg)));

    p_no_stall_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> (!stall && !accept));

    p_slot_step_r12: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> issue_tag == $past(issue_tag) + TAG_W'(1));

    p_slot_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(issue_tag));

    p_full_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && dst_en && dst_part == 2'd3) |=> !(stall && stall_reg == $past(dst_reg)));

endmodule

bind prsd_top prsd_checker #(.NREG(NREG), .TAG_W(TAG_W)) u_prsd_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .dst_en    (dst_en),
    .dst_reg   (dst_reg),
    .dst_part  (dst_part),
    .src0_en   (src0_en),
    .src0_reg  (src0_reg),
    .src1_en   (src1_en),
    .src1_reg  (src1_reg),
    .stall     (stall),
    .stall_reg (stall_reg),
    .accept    (accept),
    .issue_tag (issue_tag)
);

// File: tb/tb_prsd_top.sv
module tb_prsd_top;

    logic       clk = 1'b0;
    logic       rst_n, static_mode, in_valid, dst_en, zero_idiom;
    logic [2:0] dst_reg, src0_reg, src1_reg, stall_reg;
    logic [1:0] dst_part, src0_part, src1_part;
    logic       src0_en, src1_en, retire_valid, stall, accept;
    logic [5:0] retire_tag, issue_tag;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    prsd_top #(.NREG(8), .TAG_W(6), .DIST(4)) dut (
        .clk(clk), .rst_n(rst_n), .static_mode(static_mode), .in_valid(in_valid),
        .dst_en(dst_en), .dst_reg(dst_reg), .dst_part(dst_part), .zero_idiom(zero_idiom),
        .src0_en(src0_en), .src0_reg(src0_reg), .src0_part(src0_part),
        .src1_en(src1_en), .src1_reg(src1_reg), .src1_part(src1_part),
        .retire_valid(retire_valid), .retire_tag(retire_tag),
        .stall(stall), .stall_reg(stall_reg), .accept(accept), .issue_tag(issue_tag)
    );

    typedef struct packed {
        logic v; logic de; logic [2:0] dr; logic [1:0] dp; logic zi;
        logic s0e; logic [2:0] s0r; logic [1:0] s0p;
        logic s1e; logic [2:0] s1r; logic [1:0] s1p;
        logic es; logic [2:0] er; logic [3:0] req;
    } vec_t;

    localparam int NV = 28;
    localparam vec_t TBL [NV] = '{
        '{1,1,1,0,0, 0,0,0, 0,0,0, 0,0,2},  // R2 write r1 byte0
        '{1,0,0,0,0, 1,1,3, 0,0,0, 1,1,2},  // R2 full read stalls
        '{1,1,5,3,0, 1,6,3, 0,0,0, 0,0,2},  // R2 unrelated filler
        '{1,0,0,0,0, 0,0,0, 1,1,2, 1,1,2},  // R2 16-bit read, not adjacent
        '{1,0,0,0,0, 1,1,0, 0,0,0, 0,0,4},  // R4 same part
        '{1,1,2,1,0, 0,0,0, 0,0,0, 0,0,3},  // R3 write r2 byte1
        '{1,0,0,0,0, 1,2,0, 0,0,0, 1,2,3},  // R3 byte0 read stalls
        '{1,1,3,2,0, 0,0,0, 0,0,0, 0,0,4},  // R4 write r3 16-bit
        '{1,0,0,0,0, 1,3,0, 1,3,1, 0,0,4},  // R4 both bytes inside
        '{1,0,0,0,0, 1,3,3, 0,0,0, 1,3,2},  // R2 full after 16-bit
        '{1,1,4,3,1, 0,0,0, 0,0,0, 0,0,7},  // R7 idiom r4
        '{1,1,4,0,0, 0,0,0, 0,0,0, 0,0,7},  // R7 byte0 write
        '{1,0,0,0,0, 1,4,3, 0,0,0, 0,0,7},  // R7 full read free
        '{1,1,4,1,0, 0,0,0, 0,0,0, 0,0,7},  // R7 byte1 write
        '{1,0,0,0,0, 1,4,2, 0,0,0, 0,0,7},  // R7 16-bit read free
        '{1,1,4,3,0, 0,0,0, 0,0,0, 0,0,8},  // R8 move zero
        '{1,1,4,0,0, 0,0,0, 0,0,0, 0,0,8},  // R8 byte0 write
        '{1,0,0,0,0, 1,4,3, 0,0,0, 1,4,8},  // R8 full read stalls
        '{1,1,7,3,1, 0,0,0, 0,0,0, 0,0,9},  // R9 idiom r7
        '{1,1,7,2,0, 0,0,0, 0,0,0, 0,0,9},  // R9 16-bit write
        '{1,0,0,0,0, 1,7,3, 0,0,0, 1,7,9},  // R9 full read stalls
        '{1,1,1,3,0, 0,0,0, 0,0,0, 0,0,6},  // R6 full write r1
        '{1,0,0,0,0, 1,1,3, 0,0,0, 0,0,6},  // R6 read free
        '{1,0,0,0,0, 1,2,3, 1,3,3, 1,2,11}, // R11 source 0 wins
        '{1,0,0,0,0, 1,6,3, 1,3,3, 1,3,11}, // R11 source 1 named
        '{0,0,0,0,0, 1,2,3, 0,0,0, 0,0,11}, // R11 no valid
        '{1,1,2,3,1, 1,2,3, 1,2,3, 0,0,7},  // R7 idiom ignores sources
        '{1,0,0,0,0, 1,2,3, 0,0,0, 0,0,7}   // R7 r2 clean after idiom
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic de, input logic [2:0] dr, input logic [1:0] dp,
                         input logic zi, input logic s0e, input logic [2:0] s0r, input logic [1:0] s0p,
                         input logic s1e, input logic [2:0] s1r, input logic [1:0] s1p);
        in_valid = v; dst_en = de; dst_reg = dr; dst_part = dp; zero_idiom = zi;
        src0_en = s0e; src0_reg = s0r; src0_part = s0p;
        src1_en = s1e; src1_reg = s1r; src1_part = s1p;
    endtask

    task automatic idle();
        drive(0,0,0,0,0, 0,0,0, 0,0,0);
        retire_valid = 0; retire_tag = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; idle();
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        static_mode = 0; rst_n = 0; idle();
        do_reset();

        // R1: clean state after reset
        #1;
        chk("R1 stall", stall, 0);
        chk("R1 tag", issue_tag, 0);

        // table walk
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(TBL[i].v, TBL[i].de, TBL[i].dr, TBL[i].dp, TBL[i].zi,
                  TBL[i].s0e, TBL[i].s0r, TBL[i].s0p, TBL[i].s1e, TBL[i].s1r, TBL[i].s1p);
            #1;
            chk($sformatf("R%0d stall row %0d", TBL[i].req, i), stall, TBL[i].es);
            chk($sformatf("R%0d accept row %0d", TBL[i].req, i), accept, TBL[i].v && !TBL[i].es);
            if (TBL[i].es) chk($sformatf("R%0d reg row %0d", TBL[i].req, i), stall_reg, TBL[i].er);
        end

        // R1: reset drops a pending partial write
        @(negedge clk); drive(1,1,1,0,0, 0,0,0, 0,0,0);
        do_reset();
        drive(1,0,0,0,0, 1,1,3, 0,0,0); #1;
        chk("R1 pending cleared", stall, 0);
        chk("R1 tag zero", issue_tag, 0);

        // R5 / R12: retire by tag
        do_reset();
        drive(1,1,1,0,0, 0,0,0, 0,0,0); #1;
        chk("R12 first tag", issue_tag, 0);
        @(negedge clk); drive(1,0,0,0,0, 1,1,3, 0,0,0);
        retire_valid = 1; retire_tag = 6'd5; #1;
        chk("R5 held", stall, 1);
        @(negedge clk); retire_valid = 0; #1;
        chk("R5 wrong tag ignored", stall, 1);
        chk("R11 held not accepted", accept, 0);
        @(negedge clk); retire_valid = 1; retire_tag = 6'd0; #1;
        chk("R5 still held in pulse cycle", stall, 1);
        @(negedge clk); retire_valid = 0; #1;
        chk("R5 released", stall, 0);
        chk("R5 accepted", accept, 1);
        chk("R12 held slots counted", issue_tag, 4);

        // R10: static distance
        do_reset();
        static_mode = 1;
        drive(1,1,2,0,0, 0,0,0, 0,0,0);
        begin
            int held = 0;
            for (int k = 0; k < 10; k++) begin
                @(negedge clk); drive(1,0,0,0,0, 1,2,3, 0,0,0); #1;
                if (!stall) break;
                held++;
            end
            chk("R10 held slots", held, 4);
        end
        @(negedge clk); drive(1,1,3,1,0, 0,0,0, 0,0,0);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk); drive(1,0,0,0,0, 0,0,0, 0,0,0);
        end
        @(negedge clk); drive(1,0,0,0,0, 1,3,0, 0,0,0); #1;
        chk("R10 too close", stall, 1);
        chk("R10 reg", stall_reg, 3);
        @(negedge clk); #1;
        chk("R10 far enough", stall, 0);

        @(negedge clk); idle(); static_mode = 0;
        repeat (2) @(posedge clk);
        finish_run();
    end

endmodule